// File: doc/BRIEF.md
# Self-Clocked Header Synchronizer

This block is the host side of a serial link to a converter that returns data without a data clock. When the host marks the start of a conversion, the block waits a fixed number of system clock cycles for the result to become ready. It then sends a burst of read-clock pulses, and the converter moves one bit onto the data line on each falling edge. The board path adds a delay of a whole number of system cycles that the host does not know in advance. The block therefore oversamples the data line at several system cycles per read-clock period. Each frame opens with a fixed two-bit header, a one followed by a zero. The block takes the first high sample as the start of the frame and from that point fixes a sampling phase in the middle of each bit.

Every frame is aligned on its own. At the start of each burst the block drops the phase it locked before and searches again. If the header does not show up within a programmable search window, or its second bit is wrong, the frame is thrown away and an error flag is raised. The flag stays up until the next burst begins. A frame that passes yields a 16-bit two's-complement result and a one-cycle strobe.

Top module: `hsr_selfclk_rx`

## Requirements
- R1: After reset `rd_clk` is high, `word_valid` and `sync_err` are low, and `word` is zero.
- R2: The edge that samples `conv_start` high is followed by MSB_WAIT cycles with `rd_clk` high. `rd_clk` then gives exactly 18 low pulses. Each pulse lasts one cycle and starts a read-clock period of OS cycles (OS = 3 by default).
- R3: `rd_clk` stays high whenever no burst is running.
- R4: The bit launched on the first falling edge of the burst must be high, and the first high sample on `sdata` is taken as its leading edge. Every later bit is sampled OS/2 cycles into its own OS-cycle slot, and that phase is not changed for the rest of the frame.
- R5: The frame is sent MSB first: a one, a zero, then 16 payload bits that go to `word` unchanged. For a board delay of D cycles, `word_valid` is high for one cycle, in the cycle that follows the rising edge MSB_WAIT+D+53 edges after the edge that sampled `conv_start`.
- R6: Every board delay D from 0 to HUNT_PERIODS*OS-1 (0 to 5 by default) gives the correct word.
- R7: If there is no high sample among the first HUNT_PERIODS*OS samples of a burst, no `word_valid` is given for that frame and `sync_err` goes high. This covers a delay of 6 cycles by default and a line that stays low.
- R8: If the second header bit is sampled as one, no `word_valid` is given and `sync_err` goes high.
- R9: `sync_err` clears when the next burst begins, and the next frame is searched and phased afresh.
- R10: A `conv_start` that arrives during a wait or a burst cancels the frame in progress. `rd_clk` is high in the next cycle, the cancelled frame gives no `word_valid`, and the new conversion runs its whole timing.
- R11: `word_valid` and `sync_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; OS cycles make one read-clock period |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_start | input | 1 | One-cycle mark that a conversion has begun |
| sdata | input | 1 | Raw serial data line coming back from the converter |
| rd_clk | output | 1 | Burst read clock sent to the converter; idles high |
| word | output | 16 | Last recovered result, two's complement |
| word_valid | output | 1 | One-cycle strobe when `word` is updated |
| sync_err | output | 1 | The last frame failed its header check |

## Verification
Frames are run at every board delay inside the search window so that each of the three phase residues is used. The payloads are the two extreme codes, zero, all ones, a single low bit and mixed patterns. A wrongly chosen phase corrupts the alternating patterns, and a word slipped by one bit changes the extreme codes. Delays 5 and 6 test the last accepted position against the first rejected one. A line that never rises, and a header whose second bit is wrong, test the two error paths. A good frame after each error shows that the flag clears and the search starts again. A conversion restarted in the middle of a burst shows that the old frame is dropped and the new frame keeps its full latency.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

   // Fixed frame header: first bit high, second bit low.
   localparam int          HDR_W   = 2;
   localparam logic [1:0]  HDR_PAT = 2'b10;

   // Read-clock burst sequencer states.
   typedef enum logic [1:0] {
      CG_IDLE  = 2'd0,
      CG_WAIT  = 2'd1,
      CG_BURST = 2'd2
   } hsr_cg_e;

endpackage

// File: rtl/hsr_burst_gen.sv
module hsr_burst_gen
   import hsr_pkg::*;
#(
   parameter int OS       = 3,
   parameter int FRAME_W  = 18,
   parameter int MSB_WAIT = 37,
   parameter int PH_W     = $clog2(OS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            conv_start,
   output logic            rd_clk,
   output logic            arm,
   output logic [PH_W-1:0] ph
);

   localparam int WAIT_W = $clog2(MSB_WAIT) + 1;
   localparam int PER_W  = $clog2(FRAME_W) + 1;

   hsr_cg_e           cg_q;
   logic [WAIT_W-1:0] wait_q;
   logic [PER_W-1:0]  per_q;
   logic [PH_W-1:0]   ph_q;
   logic              ph_last;

   generate
      if (MSB_WAIT < 1) begin : g_bad_wait
         $error("hsr_burst_gen: MSB_WAIT must be at least 1");
      end
   endgenerate

   assign ph_last = (ph_q == PH_W'(OS - 1));

   // The burst starts on the edge that ends the last wait cycle.
   always_comb begin
      arm = (cg_q == CG_WAIT) && (wait_q == WAIT_W'(MSB_WAIT - 1)) && !conv_start;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cg_q   <= CG_IDLE;
         wait_q <= '0;
         per_q  <= '0;
      end else if (conv_start) begin
         cg_q   <= CG_WAIT;
         wait_q <= '0;
      end else begin
         unique case (cg_q)
            CG_WAIT: begin
               if (arm) begin
                  cg_q  <= CG_BURST;
                  per_q <= '0;
               end else begin
                  wait_q <= wait_q + 1'b1;
               end
            end
            CG_BURST: begin
               if (ph_last) begin
                  if (per_q == PER_W'(FRAME_W - 1)) begin
                     cg_q <= CG_IDLE;
                  end else begin
                     per_q <= per_q + 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   // Phase counter is realigned at each burst and keeps running afterwards,
   // so the receiver can finish sampling the delayed tail of the frame.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= '0;
      end else if (arm || ph_last) begin
         ph_q <= '0;
      end else begin
         ph_q <= ph_q + 1'b1;
      end
   end

   assign ph     = ph_q;
   assign rd_clk = !((cg_q == CG_BURST) && (ph_q == '0));

endmodule

// File: rtl/hsr_phase_det.sv
module hsr_phase_det #(
   parameter int OS           = 3,
   parameter int HUNT_PERIODS = 2,
   parameter int PH_W         = $clog2(OS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            arm,
   input  logic            abort,
   input  logic            sdata,
   input  logic [PH_W-1:0] ph,
   output logic            lock,
   output logic [PH_W-1:0] lock_ph,
   output logic            timeout
);

   localparam int HUNT_LEN = HUNT_PERIODS * OS;
   localparam int HC_W     = $clog2(HUNT_LEN) + 1;
   localparam int CENTER   = OS / 2;

   logic            hunting_q;
   logic [HC_W-1:0] hcnt_q;

   generate
      if (OS < 3 || (OS % 2) == 0) begin : g_bad_os
         $error("hsr_phase_det: OS must be odd and at least 3");
      end
      if (HUNT_PERIODS < 1) begin : g_bad_hunt
         $error("hsr_phase_det: HUNT_PERIODS must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hunting_q <= 1'b0;
         hcnt_q    <= '0;
         lock      <= 1'b0;
         lock_ph   <= '0;
         timeout   <= 1'b0;
      end else begin
         lock <= 1'b0;
         if (abort) begin
            hunting_q <= 1'b0;
         end else if (arm) begin
            hunting_q <= 1'b1;
            hcnt_q    <= '0;
            timeout   <= 1'b0;
         end else if (hunting_q) begin
            if (sdata) begin
               // Leading edge found: the bit centre lies CENTER cycles later.
               hunting_q <= 1'b0;
               lock      <= 1'b1;
               lock_ph   <= PH_W'((32'(ph) + CENTER) % OS);
            end else if (hcnt_q == HC_W'(HUNT_LEN - 1)) begin
               hunting_q <= 1'b0;
               timeout   <= 1'b1;
            end else begin
               hcnt_q <= hcnt_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/hsr_deser.sv
module hsr_deser
   import hsr_pkg::*;
#(
   parameter int OS     = 3,
   parameter int DATA_W = 16,
   parameter int PH_W   = $clog2(OS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              abort,
   input  logic              sdata,
   input  logic [PH_W-1:0]   ph,
   input  logic              lock,
   input  logic [PH_W-1:0]   lock_ph,
   output logic [DATA_W-1:0] word,
   output logic              valid,
   output logic              hdr_err
);

   localparam int FRAME_W = HDR_W + DATA_W;
   localparam int K_W     = $clog2(FRAME_W + 1);

   logic              trk_q;
   logic [PH_W-1:0]   sel_q;
   logic [PH_W-1:0]   sel_ph;
   logic [K_W-1:0]    k_q;
   logic [DATA_W-2:0] sh_q;
   logic [OS-1:0]     ph_oh;
   logic [OS-1:0]     sel_oh;
   logic              take;

   generate
      if (DATA_W < 3) begin : g_bad_w
         $error("hsr_deser: DATA_W must be at least 3");
      end
      for (genvar p = 0; p < OS; p++) begin : g_phase
         assign ph_oh[p]  = (ph == PH_W'(p));
         assign sel_oh[p] = (sel_ph == PH_W'(p));
      end
   endgenerate

   assign sel_ph = lock ? lock_ph : sel_q;
   assign take   = (lock || trk_q) && |(ph_oh & sel_oh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trk_q   <= 1'b0;
         sel_q   <= '0;
         k_q     <= '0;
         sh_q    <= '0;
         word    <= '0;
         valid   <= 1'b0;
         hdr_err <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (abort) begin
            trk_q <= 1'b0;
         end else if (arm) begin
            trk_q   <= 1'b0;
            k_q     <= '0;
            hdr_err <= 1'b0;
         end else begin
            if (lock) begin
               trk_q <= 1'b1;
               sel_q <= lock_ph;
            end
            if (take) begin
               k_q <= k_q + 1'b1;
               if (k_q < K_W'(HDR_W)) begin
                  if (sdata != HDR_PAT[HDR_W - 1 - int'(k_q)]) begin
                     hdr_err <= 1'b1;
                     trk_q   <= 1'b0;
                  end
               end else if (k_q == K_W'(FRAME_W - 1)) begin
                  word  <= {sh_q, sdata};
                  valid <= 1'b1;
                  trk_q <= 1'b0;
               end else begin
                  sh_q <= {sh_q[DATA_W-3:0], sdata};
               end
            end
         end
      end
   end

endmodule

// File: rtl/hsr_selfclk_rx.sv
module hsr_selfclk_rx
   import hsr_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int OS           = 3,
   parameter int MSB_WAIT     = 37,
   parameter int HUNT_PERIODS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_start,
   input  logic              sdata,
   output logic              rd_clk,
   output logic [DATA_W-1:0] word,
   output logic              word_valid,
   output logic              sync_err
);

   localparam int FRAME_W = HDR_W + DATA_W;
   localparam int PH_W    = $clog2(OS);

   logic            arm;
   logic [PH_W-1:0] ph;
   logic            lock;
   logic [PH_W-1:0] lock_ph;
   logic            timeout;
   logic            hdr_err;

   hsr_burst_gen #(
      .OS       (OS),
      .FRAME_W  (FRAME_W),
      .MSB_WAIT (MSB_WAIT),
      .PH_W     (PH_W)
   ) i_burst (
      .clk        (clk),
      .rst_n      (rst_n),
      .conv_start (conv_start),
      .rd_clk     (rd_clk),
      .arm        (arm),
      .ph         (ph)
   );

   hsr_phase_det #(
      .OS           (OS),
      .HUNT_PERIODS (HUNT_PERIODS),
      .PH_W         (PH_W)
   ) i_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (arm),
      .abort   (conv_start),
      .sdata   (sdata),
      .ph      (ph),
      .lock    (lock),
      .lock_ph (lock_ph),
      .timeout (timeout)
   );

   hsr_deser #(
      .OS     (OS),
      .DATA_W (DATA_W),
      .PH_W   (PH_W)
   ) i_deser (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (arm),
      .abort   (conv_start),
      .sdata   (sdata),
      .ph      (ph),
      .lock    (lock),
      .lock_ph (lock_ph),
      .word    (word),
      .valid   (word_valid),
      .hdr_err (hdr_err)
   );

   assign sync_err = timeout | hdr_err;

endmodule

// File: rtl/hsr_selfclk_rx_chk.sv
module hsr_selfclk_rx_chk #(
   parameter int FRAME_W = 18
) (
   input logic clk,
   input logic rst_n,
   input logic conv_start,
   input logic rd_clk,
   input logic word_valid,
   input logic sync_err
);

   localparam int PC_W = $clog2(FRAME_W + 1) + 1;

   logic            rd_q;
   logic [PC_W-1:0] pcnt_q;

   // Counts falling read-clock edges since the last conversion start.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q   <= 1'b1;
         pcnt_q <= '0;
      end else begin
         rd_q <= rd_clk;
         if (conv_start) begin
            pcnt_q <= '0;
         end else if (rd_q && !rd_clk) begin
            pcnt_q <= pcnt_q + 1'b1;
         end
      end
   end

   AST_RDCLK_LOW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_clk |=> rd_clk); // R2
   AST_BURST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt_q <= PC_W'(FRAME_W)); // R2
   AST_IDLE_HIGH_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      (pcnt_q == PC_W'(FRAME_W)) |-> rd_clk); // R3
   AST_VALID_AFTER_FULL_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> (pcnt_q == PC_W'(FRAME_W))); // R5
   AST_VALID_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid); // R5
   AST_RESTART_STOPS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> rd_clk); // R10
   AST_VALID_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(word_valid && sync_err)); // R11

endmodule

bind hsr_selfclk_rx hsr_selfclk_rx_chk #(.FRAME_W(FRAME_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .conv_start (conv_start),
   .rd_clk     (rd_clk),
   .word_valid (word_valid),
   .sync_err   (sync_err)
);

// File: tb/test_hsr_selfclk_rx.sv
`timescale 1ns/1ps
module test_hsr_selfclk_rx;

   localparam int W  = 37;
   localparam int NV = 8;
   localparam logic [15:0] VEC_DATA [NV] = '{16'h8000, 16'h7FFF, 16'hA5C3, 16'h0001,
                                             16'hFFFF, 16'h0000, 16'h5555, 16'hFEC9};
   localparam int VEC_DLY [NV] = '{0, 1, 2, 3, 4, 5, 0, 2};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_start = 1'b0;
   logic        sdata = 1'b0;
   logic        rd_clk;
   logic [15:0] word;
   logic        word_valid;
   logic        sync_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // converter model state
   logic [17:0] m_frm = '0;
   int          m_bi = 18;
   logic        m_cur = 1'b0;
   logic [7:0]  m_dl = '0;
   int          m_d = 0;
   logic        m_prev = 1'b1;

   always #2 clk = ~clk;

   hsr_selfclk_rx i_hsr_selfclk_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .conv_start (conv_start),
      .sdata      (sdata),
      .rd_clk     (rd_clk),
      .word       (word),
      .word_valid (word_valid),
      .sync_err   (sync_err)
   );

   // Converter: launches the next frame bit on each falling read-clock edge,
   // seen by the host m_d cycles later.
   initial begin
      forever begin
         @(negedge clk);
         if (rd_clk == 1'b0 && m_prev == 1'b1 && m_bi < 18) begin
            m_cur = m_frm[17 - m_bi];
            m_bi++;
         end
         m_prev = rd_clk;
         m_dl   = {m_dl[6:0], m_cur};
         sdata  = m_dl[m_d];
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                  req, what, act, act, exp, exp);
      end
   endtask

   task automatic run_word(input logic [17:0] frm, input int d, input bit good,
                           input string req);
      int vat = -1;
      int vcnt = 0;
      int lows = 0;
      int both = 0;
      m_frm = frm;
      @(negedge clk);
      conv_start = 1'b1;
      @(posedge clk);
      #1;
      m_bi = 0; m_cur = 1'b0; m_dl = '0; m_d = d;
      @(negedge clk);
      conv_start = 1'b0;
      chk(rd_clk == 1'b1, "R10", "rd_clk high after start", int'(rd_clk), 1);
      for (int n = 0; n < W + d + 80; n++) begin
         if (n > 0) @(negedge clk);
         if (word_valid) begin
            vcnt++;
            if (vat < 0) vat = n;
         end
         if (!rd_clk) lows++;
         if (word_valid && sync_err) both++;
      end
      chk(lows == 18, "R2", "read-clock low pulses", lows, 18);
      chk(both == 0, "R11", "valid with error", both, 0);
      if (good) begin
         chk(vat == W + d + 53, "R5", "valid latency", vat, W + d + 53);
         chk(vcnt == 1, "R5", "valid strobe count", vcnt, 1);
         chk(word == frm[15:0], req, "recovered word", int'(word), int'(frm[15:0]));
         chk(sync_err == 1'b0, "R9", "sync_err after good word", int'(sync_err), 0);
      end else begin
         chk(vcnt == 0, req, "no valid on bad frame", vcnt, 0);
         chk(sync_err == 1'b1, req, "sync_err raised", int'(sync_err), 1);
      end
   endtask

   initial begin
      fork
         begin
            repeat (150000) @(posedge clk);
            if (!done) begin
               checks++;
               errors++;
               $display("FAIL watchdog: actual timeout expected completion");
               $display("Simulation finished: %0d checks, %0d errors", checks, errors);
               $finish;
            end
         end
      join_none

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(rd_clk == 1'b1, "R1", "rd_clk in reset", int'(rd_clk), 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(rd_clk == 1'b1, "R1", "rd_clk after reset", int'(rd_clk), 1);
      chk(word_valid == 1'b0, "R1", "word_valid after reset", int'(word_valid), 0);
      chk(sync_err == 1'b0, "R1", "sync_err after reset", int'(sync_err), 0);
      chk(word == 16'h0, "R1", "word after reset", int'(word), 0);
      repeat (5) @(negedge clk);
      chk(rd_clk == 1'b1, "R3", "rd_clk idle without start", int'(rd_clk), 1);

      // Table walk: payloads across delays 0..5 (R4, R5, R6)
      for (int i = 0; i < NV; i++) begin
         run_word({2'b10, VEC_DATA[i]}, VEC_DLY[i], 1'b1, "R6");
      end

      // R6 edge: last delay inside the search window, phase R4
      run_word({2'b10, 16'h3C96}, 5, 1'b1, "R4");

      // R7: first delay outside the window
      run_word({2'b10, 16'h1234}, 6, 1'b0, "R7");
      // R9: recovery with a fresh phase
      run_word({2'b10, 16'h1234}, 1, 1'b1, "R9");
      // R7: line that never rises
      run_word(18'h0, 0, 1'b0, "R7");
      // R8: second header bit high
      run_word({2'b11, 16'h0F0F}, 2, 1'b0, "R8");
      // R9: recovery after header error
      run_word({2'b10, 16'hC001}, 4, 1'b1, "R9");

      // R10: restart mid-burst
      m_frm = {2'b10, 16'hAAAA};
      @(negedge clk);
      conv_start = 1'b1;
      @(posedge clk);
      #1;
      m_bi = 0; m_cur = 1'b0; m_dl = '0; m_d = 0;
      @(negedge clk);
      conv_start = 1'b0;
      repeat (W + 12) @(negedge clk);
      chk(word_valid == 1'b0, "R10", "no valid in aborted frame", int'(word_valid), 0);
      run_word({2'b10, 16'h6B2D}, 3, 1'b1, "R10");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule